// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

The block turns one host request into one access cycle on an asynchronous parallel NAND flash bus. A request is tagged as data, command or address. It carries a direction and, for writes, a data word. The sequencer drives the chip enables, the command latch and address latch enables, the read and write strobes and the data-bus output enable. It steps them through setup, wait and hold phases whose lengths are counted in clock cycles. A separate high-impedance count delays the data driver on writes.

There are two timing words. Data transfers use the common word, and command and address writes use the attribute word. After a command or address write, a data read is held off by a programmable command-to-read or address-to-read delay. The wait phase can be stretched while the device reports busy. A small configuration port loads the two timing words and a control word. The host side uses a valid/ready handshake and gets a one-cycle done pulse at the end of every access. That pulse carries the read word on reads.

Top module: `nand_bus_seq`

## Requirements
- R1: A timing word holds setup in bits 7:0, wait in bits 15:8, hold in bits 23:16 and high-Z count in bits 31:24. An access shows setup cycles with chip enable asserted and the strobe high, then wait cycles with the strobe low, then hold cycles with the strobe high. A setup, wait or hold field of 0 is used as 1.
- R2: After reset both timing words are 0x0A0A0A0A, both read delays are 15, the bus is 8 bits wide and wait-enable is off. Configuration select 0 writes the common word, 1 the attribute word and 2 the control word.
- R3: Requests of kind 0 (data) use the common timing word. Kinds 1 (command) and 2 (address) use the attribute word.
- R4: A command request asserts CLE and an address request asserts ALE for the whole setup/wait/hold span. Both are always writes that pulse the write strobe, whatever the direction input says, and drive only the low byte.
- R5: On writes the data driver turns on once high-Z count cycles have passed since the start of setup, and stays on through hold. It never turns on when that count reaches past the end of hold, and never on reads.
- R6: A data read that directly follows a command write inserts control bits 3:0 extra cycles before setup. One that directly follows an address write inserts control bits 7:4 extra cycles. Any other read inserts none.
- R7: Control bit 8 selects the data width: 0 for 8 bits, 1 for 16 bits. In 8-bit mode the upper byte of written data is driven as zero and the upper byte of read data returns as zero.
- R8: Only the chip enable picked by the request is asserted (low), and only for the duration of the access.
- R9: With control bit 9 set, every wait-phase cycle in which the ready line is low adds one wait cycle. With the bit clear, the ready line has no effect.
- R10: Ready is high only while idle. Done pulses for one cycle in the first idle cycle after hold. A read returns the bus value sampled in the last wait cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | 0 common word, 1 attribute word, 2 control word |
| cfg_wdata_i | input | 32 | Configuration write data |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request accepted |
| req_kind_i | input | 2 | 0 data, 1 command, 2 address |
| req_write_i | input | 1 | Direction of a data request, 1 = write |
| req_cs_i | input | CS_W (1) | Chip enable index |
| req_wdata_i | input | DQ_W (16) | Write data |
| done_o | output | 1 | Access finished pulse |
| rd_data_o | output | DQ_W (16) | Read data, valid with done |
| nand_ce_no | output | NUM_CE (2) | Chip enables, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | DQ_W (16) | Data bus out |
| nand_dq_oe_o | output | 1 | Data bus output enable |
| nand_dq_i | input | DQ_W (16) | Data bus in |
| nand_rdy_i | input | 1 | Device ready, low when busy |

## Verification
The busy-stretch of the wait phase and the read-data capture meet in the same cycle. The last wait cycle is the first one in which ready comes back high, and the word is sampled in exactly that cycle. The bench device model pulls ready low for a chosen number of wait cycles. It also changes its data bus every cycle the read strobe is low, to a base value plus the count of low cycles so far. The captured word must therefore equal the base plus the full stretched wait length, and the measured strobe-low width must equal wait plus busy cycles.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_ADDR = 2'd2,
    KIND_RSVD = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PRE   = 3'd1,
    PH_SETUP = 3'd2,
    PH_WAIT  = 3'd3,
    PH_HOLD  = 3'd4
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] hiz;
    logic [CNT_W-1:0] hold;
    logic [CNT_W-1:0] wt;
    logic [CNT_W-1:0] setup;
  } timing_t;

  localparam logic [31:0] TIMING_RST = 32'h0A0A_0A0A;

  // zero is used as one
  function automatic logic [CNT_W-1:0] cnt_load(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction
endpackage

// File: rtl/nand_seq_cfg.sv
module nand_seq_cfg
  import nand_seq_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [31:0]      cfg_wdata_i,
  output timing_t          common_o,
  output timing_t          attr_o,
  output logic [DLY_W-1:0] cle_re_o,
  output logic [DLY_W-1:0] ale_re_o,
  output logic             wide_o,
  output logic             wait_en_o
);
  localparam int WIDE_BIT = 2 * DLY_W;
  localparam int WAIT_BIT = 2 * DLY_W + 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      common_o  <= timing_t'(TIMING_RST);
      attr_o    <= timing_t'(TIMING_RST);
      cle_re_o  <= '1;
      ale_re_o  <= '1;
      wide_o    <= 1'b0;
      wait_en_o <= 1'b0;
    end else if (cfg_wr_i) begin
      case (cfg_sel_i)
        2'd0: common_o <= timing_t'(cfg_wdata_i);
        2'd1: attr_o   <= timing_t'(cfg_wdata_i);
        2'd2: begin
          cle_re_o  <= cfg_wdata_i[DLY_W-1:0];
          ale_re_o  <= cfg_wdata_i[2*DLY_W-1:DLY_W];
          wide_o    <= cfg_wdata_i[WIDE_BIT];
          wait_en_o <= cfg_wdata_i[WAIT_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int DQ_W  = 16,
  parameter int CS_W  = 1,
  parameter int DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_kind_i,
  input  logic             req_write_i,
  input  logic [CS_W-1:0]  req_cs_i,
  input  logic [DQ_W-1:0]  req_wdata_i,
  input  timing_t          common_i,
  input  timing_t          attr_i,
  input  logic [DLY_W-1:0] cle_re_i,
  input  logic [DLY_W-1:0] ale_re_i,
  input  logic             wide_i,
  input  logic             wait_en_i,
  input  logic             rdy_i,
  input  logic [DQ_W-1:0]  dq_i,
  output phase_e           phase_o,
  output req_kind_e        kind_o,
  output logic             wr_o,
  output logic [CS_W-1:0]  cs_o,
  output logic [DQ_W-1:0]  wdata_o,
  output logic             hz_done_o,
  output logic             done_o,
  output logic [DQ_W-1:0]  rd_data_o
);
  localparam int HALF_W = DQ_W / 2;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q, hz_q;
  timing_t          cur_t_q;
  req_kind_e        last_q;
  timing_t          sel_t;
  logic [CNT_W-1:0] pre_dly;
  logic             is_rd_req, stall;
  logic [DQ_W-1:0]  sample;

  always_comb begin
    sel_t     = (req_kind_e'(req_kind_i) == KIND_DATA) ? common_i : attr_i;
    is_rd_req = (req_kind_e'(req_kind_i) == KIND_DATA) && !req_write_i;
    case (last_q)
      KIND_CMD:  pre_dly = CNT_W'(cle_re_i);
      KIND_ADDR: pre_dly = CNT_W'(ale_re_i);
      default:   pre_dly = '0;
    endcase
    stall  = wait_en_i && !rdy_i;
    sample = wide_i ? dq_i : {{(DQ_W-HALF_W){1'b0}}, dq_i[HALF_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      hz_q      <= '0;
      cur_t_q   <= '0;
      last_q    <= KIND_DATA;
      kind_o    <= KIND_DATA;
      wr_o      <= 1'b0;
      cs_o      <= '0;
      wdata_o   <= '0;
      done_o    <= 1'b0;
      rd_data_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (phase_q != PH_IDLE && hz_q != '0) hz_q <= hz_q - 1'b1;
      case (phase_q)
        PH_IDLE: if (req_valid_i) begin
          kind_o  <= req_kind_e'(req_kind_i);
          wr_o    <= !is_rd_req;
          cs_o    <= req_cs_i;
          wdata_o <= req_wdata_i;
          cur_t_q <= sel_t;
          hz_q    <= sel_t.hiz;
          if (is_rd_req && pre_dly != '0) begin
            phase_q <= PH_PRE;
            cnt_q   <= pre_dly - 1'b1;
          end else begin
            phase_q <= PH_SETUP;
            cnt_q   <= cnt_load(sel_t.setup);
          end
        end
        PH_PRE: if (cnt_q == '0) begin
          phase_q <= PH_SETUP;
          cnt_q   <= cnt_load(cur_t_q.setup);
        end else cnt_q <= cnt_q - 1'b1;
        PH_SETUP: if (cnt_q == '0) begin
          phase_q <= PH_WAIT;
          cnt_q   <= cnt_load(cur_t_q.wt);
        end else cnt_q <= cnt_q - 1'b1;
        PH_WAIT: if (!stall) begin
          if (cnt_q == '0) begin
            phase_q <= PH_HOLD;
            cnt_q   <= cnt_load(cur_t_q.hold);
            if (!wr_o) rd_data_o <= sample;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_HOLD: if (cnt_q == '0) begin
          phase_q <= PH_IDLE;
          done_o  <= 1'b1;
          last_q  <= kind_o;
        end else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign req_ready_o = (phase_q == PH_IDLE);
  assign phase_o     = phase_q;
  assign hz_done_o   = (hz_q == '0);

  // R9
  wait_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WAIT && wait_en_i && !rdy_i) |=> (phase_q == PH_WAIT));
  // R10
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  pre_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PRE) |-> (!wr_o && kind_o == KIND_DATA));
endmodule

// File: rtl/nand_seq_pins.sv
module nand_seq_pins
  import nand_seq_pkg::*;
#(
  parameter int NUM_CE = 2,
  parameter int DQ_W   = 16,
  parameter int CS_W   = 1
) (
  input  phase_e          phase_i,
  input  req_kind_e       kind_i,
  input  logic            wr_i,
  input  logic [CS_W-1:0] cs_i,
  input  logic [DQ_W-1:0] wdata_i,
  input  logic            hz_done_i,
  input  logic            wide_i,
  output logic [NUM_CE-1:0] ce_no,
  output logic            cle_o,
  output logic            ale_o,
  output logic            we_no,
  output logic            re_no,
  output logic [DQ_W-1:0] dq_o,
  output logic            dq_oe_o
);
  localparam int HALF_W = DQ_W / 2;

  logic in_acc, in_cyc, strobe;

  assign in_acc = (phase_i != PH_IDLE);
  assign in_cyc = (phase_i == PH_SETUP) || (phase_i == PH_WAIT) || (phase_i == PH_HOLD);
  assign strobe = (phase_i == PH_WAIT);

  for (genvar g = 0; g < NUM_CE; g++) begin : g_ce
    assign ce_no[g] = !(in_acc && cs_i == CS_W'(g));
  end

  assign cle_o   = in_cyc && (kind_i == KIND_CMD);
  assign ale_o   = in_cyc && (kind_i == KIND_ADDR);
  assign we_no   = !(strobe && wr_i);
  assign re_no   = !(strobe && !wr_i);
  assign dq_oe_o = in_cyc && wr_i && hz_done_i;
  assign dq_o    = (kind_i == KIND_DATA && wide_i) ? wdata_i
                 : {{(DQ_W-HALF_W){1'b0}}, wdata_i[HALF_W-1:0]};
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nand_seq_pkg::*;
#(
  parameter  int NUM_CE = 2,
  parameter  int DQ_W   = 16,
  parameter  int DLY_W  = 4,
  localparam int CS_W   = (NUM_CE > 1) ? $clog2(NUM_CE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic              req_write_i,
  input  logic [CS_W-1:0]   req_cs_i,
  input  logic [DQ_W-1:0]   req_wdata_i,
  output logic              done_o,
  output logic [DQ_W-1:0]   rd_data_o,
  output logic [NUM_CE-1:0] nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [DQ_W-1:0]   nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [DQ_W-1:0]   nand_dq_i,
  input  logic              nand_rdy_i
);
  timing_t          common_t, attr_t;
  logic [DLY_W-1:0] cle_re, ale_re;
  logic             wide, wait_en, wr, hz_done;
  phase_e           phase;
  req_kind_e        kind;
  logic [CS_W-1:0]  cs;
  logic [DQ_W-1:0]  wdata;

  nand_seq_cfg #(.DLY_W(DLY_W)) i_cfg (
    .clk_i, .rst_ni, .cfg_wr_i, .cfg_sel_i, .cfg_wdata_i,
    .common_o(common_t), .attr_o(attr_t), .cle_re_o(cle_re), .ale_re_o(ale_re),
    .wide_o(wide), .wait_en_o(wait_en)
  );

  nand_seq_fsm #(.DQ_W(DQ_W), .CS_W(CS_W), .DLY_W(DLY_W)) i_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_kind_i, .req_write_i,
    .req_cs_i, .req_wdata_i, .common_i(common_t), .attr_i(attr_t),
    .cle_re_i(cle_re), .ale_re_i(ale_re), .wide_i(wide), .wait_en_i(wait_en),
    .rdy_i(nand_rdy_i), .dq_i(nand_dq_i), .phase_o(phase), .kind_o(kind),
    .wr_o(wr), .cs_o(cs), .wdata_o(wdata), .hz_done_o(hz_done), .done_o,
    .rd_data_o
  );

  nand_seq_pins #(.NUM_CE(NUM_CE), .DQ_W(DQ_W), .CS_W(CS_W)) i_pins (
    .phase_i(phase), .kind_i(kind), .wr_i(wr), .cs_i(cs), .wdata_i(wdata),
    .hz_done_i(hz_done), .wide_i(wide), .ce_no(nand_ce_no), .cle_o(nand_cle_o),
    .ale_o(nand_ale_o), .we_no(nand_we_no), .re_no(nand_re_no),
    .dq_o(nand_dq_o), .dq_oe_o(nand_dq_oe_o)
  );

  // R8
  ce_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~nand_ce_no));
  // R4
  cle_ale_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));
  // R1
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nand_we_no || nand_re_no));
  // R5
  oe_not_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_dq_oe_o |-> (nand_re_no && nand_ce_no != '1));
  // R10
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (nand_ce_no == '1));
endmodule

// File: tb/test_nand_bus_seq.sv
`timescale 1ns/1ps
module test_nand_bus_seq;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0; logic [1:0] cfg_sel = 0; logic [31:0] cfg_wdata = 0;
  logic req_valid = 0, req_ready, req_write = 0, req_cs = 0;
  logic [1:0] req_kind = 0; logic [15:0] req_wdata = 0;
  logic done; logic [15:0] rd_data;
  logic [1:0] nand_ce_n; logic cle, ale, we_n, re_n, dq_oe;
  logic [15:0] dq_out, dq_in = 0; logic rdy = 1;

  always #2 clk = ~clk;

  nand_bus_seq i_nand_bus_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_write_i(req_write), .req_cs_i(req_cs),
    .req_wdata_i(req_wdata), .done_o(done), .rd_data_o(rd_data),
    .nand_ce_no(nand_ce_n), .nand_cle_o(cle), .nand_ale_o(ale),
    .nand_we_no(we_n), .nand_re_no(re_n), .nand_dq_o(dq_out),
    .nand_dq_oe_o(dq_oe), .nand_dq_i(dq_in), .nand_rdy_i(rdy)
  );

  typedef struct packed {
    int pre; int low; int post; int oe_first;
    bit cle; bit ale; bit is_rd; bit cs; logic [15:0] data;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, fails = 0;
  bit finished = 0;
  // shadow configuration, from R2
  logic [31:0] sh_common = 32'h0A0A0A0A, sh_attr = 32'h0A0A0A0A;
  int sh_cle = 15, sh_ale = 15; bit sh_wide = 0, sh_wait = 0;
  int sh_last = 0;

  int busy_left = 0; logic [15:0] rd_base = 0;
  int m_idx = 0, m_pre = 0, m_low = 0, m_post = 0, m_oe = -1;
  bit m_cle = 0, m_ale = 0, m_re = 0, m_cs = 0, m_rdy_bad = 0;
  logic [15:0] m_wd = 0;

  task automatic chk(input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  function automatic int cl(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  // monitor / scoreboard and device model
  always @(negedge clk) begin
    if (rst_n) begin
      if (nand_ce_n != 2'b11) begin
        m_idx++;
        m_cs = nand_ce_n[0];
        if (req_ready) m_rdy_bad = 1;
        if (!we_n || !re_n) begin
          m_low++;
          if (!re_n) m_re = 1;
          dq_in = rd_base + 16'(m_low);
          if (busy_left > 0) begin rdy = 0; busy_left--; end else rdy = 1;
        end else begin
          rdy = 1;
          if (m_low == 0) m_pre++; else m_post++;
        end
        if (cle) m_cle = 1;
        if (ale) m_ale = 1;
        if (dq_oe) begin
          if (m_oe < 0) m_oe = m_idx - 1;
          m_wd = dq_out;
        end
      end else rdy = 1;
      if (done) begin
        if (exp_q.size() == 0) chk("R10 done without request", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk("R1/R6 cycles before strobe", m_pre, e.pre);
          chk("R1/R9 strobe low cycles", m_low, e.low);
          chk("R1 hold cycles", m_post, e.post);
          chk("R5 driver-on cycle", m_oe, e.oe_first);
          chk("R4 CLE", int'(m_cle), int'(e.cle));
          chk("R4 ALE", int'(m_ale), int'(e.ale));
          chk("R4 read strobe used", int'(m_re), int'(e.is_rd));
          chk("R8 chip enable index", int'(m_cs), int'(e.cs));
          chk("R10 ready during access", int'(m_rdy_bad), 0);
          if (e.is_rd) chk("R10/R7 read data", int'(rd_data), int'(e.data));
          else if (e.oe_first >= 0) chk("R4/R7 write data", int'(m_wd), int'(e.data));
        end
        m_idx = 0; m_pre = 0; m_low = 0; m_post = 0; m_oe = -1;
        m_cle = 0; m_ale = 0; m_re = 0; m_rdy_bad = 0; m_wd = 0;
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    case (sel)
      2'd0: sh_common = d;
      2'd1: sh_attr = d;
      default: begin
        sh_cle = int'(d[3:0]); sh_ale = int'(d[7:4]);
        sh_wide = d[8]; sh_wait = d[9];
      end
    endcase
  endtask

  // driver: computes expectation from the requirements, then drives
  task automatic access(input int kind, input bit wr, input bit cs,
                        input logic [15:0] wd, input int k, input logic [15:0] base);
    exp_t e;
    logic [31:0] t;
    int s, w, h, z, d;
    logic [15:0] v;
    t = (kind == 0) ? sh_common : sh_attr;              // R3
    s = cl(t[7:0]); w = cl(t[15:8]); h = cl(t[23:16]); z = int'(t[31:24]);
    e.is_rd = (kind == 0) && !wr;                       // R4: cmd/addr always write
    d = 0;
    if (e.is_rd) d = (sh_last == 1) ? sh_cle : (sh_last == 2) ? sh_ale : 0; // R6
    if (sh_wait) w = w + k;                             // R9
    e.pre = d + s; e.low = w; e.post = h;
    e.oe_first = e.is_rd ? -1 : ((z < s + w + h) ? z : -1);
    e.cle = (kind == 1); e.ale = (kind == 2); e.cs = cs;
    if (e.is_rd) v = base + 16'(w); else v = wd;
    e.data = (kind == 0 && sh_wide) ? v : {8'h00, v[7:0]}; // R7
    sh_last = kind;
    exp_q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_base = base; busy_left = k;
    req_valid = 1; req_kind = 2'(kind); req_write = wr; req_cs = cs; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      fails++;
      $display("FAIL R10 watchdog expired: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2/R8/R10 reset state
    chk("R10 ready after reset", int'(req_ready), 1);
    chk("R8 chip enables idle", int'(nand_ce_n), 3);
    chk("R1 strobes idle", int'({we_n, re_n}), 3);
    chk("R5 driver off after reset", int'(dq_oe), 0);
    chk("R10 done idle", int'(done), 0);
    // R2 defaults, R7 8-bit read
    access(0, 0, 0, 16'h0000, 0, 16'h5A30);
    // R4 command with direction input low, R3 attribute word, R8 second CE
    access(1, 0, 1, 16'h1290, 0, 16'h0000);
    // R6 default command-to-read delay
    access(0, 0, 0, 16'h0000, 0, 16'h1100);
    access(2, 1, 0, 16'h0077, 0, 16'h0000);
    access(0, 0, 1, 16'h0000, 0, 16'h2200);
    // new configuration: R1 fields, R7 wide, R9 wait enable
    cfg_write(2'd2, 32'h0000_0335);
    cfg_write(2'd0, 32'h0203_0402);
    cfg_write(2'd1, 32'h0002_0501);
    access(1, 1, 0, 16'hAB5C, 3, 16'h0000);  // R9 stretched write
    access(0, 0, 1, 16'h0000, 2, 16'hC0F0);  // R6 + R9 + R10 sample
    access(0, 1, 0, 16'hBEEF, 0, 16'h0000);  // R5 + R7 wide write
    access(2, 1, 1, 16'hC3A5, 0, 16'h0000);
    access(0, 0, 0, 16'h0000, 1, 16'h7F00);  // R6 address delay
    access(0, 0, 0, 16'h0000, 0, 16'h3300);  // R6 no delay after data
    // R1 zero fields used as one, R5 high-Z past hold
    cfg_write(2'd0, 32'h4000_0000);
    access(0, 1, 1, 16'h1357, 0, 16'h0000);
    cfg_write(2'd0, 32'h0000_0000);
    access(0, 1, 0, 16'h1234, 0, 16'h0000);
    // R9 ready ignored with wait enable off, R7 back to 8 bits
    cfg_write(2'd2, 32'h0000_0035);
    cfg_write(2'd0, 32'h0001_0301);
    access(0, 0, 0, 16'h0000, 4, 16'h9AF0);
    access(0, 1, 1, 16'hABCD, 0, 16'h0000);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule